// File: doc/BRIEF.md
# Dual-Queue Conversion Command Sequencer

The sequencer steps through a shared table of 64 conversion command entries for two queues. Queue 1 has the higher priority and starts at entry 0. Queue 2 has the lower priority and starts at an entry set by a boundary input, so queue 1 occupies the entries below that boundary and queue 2 occupies the rest.

Each entry carries two flags. A pause flag divides a queue into subqueues. An end flag finishes the queue before its last entry. For the current entry the block raises a one-cycle start strobe with the entry index. It then waits for a done pulse from the converter before it moves on. At each pause and at each end it pulses a per-queue flag.

A queue 1 trigger that arrives while queue 2 is converting abandons that conversion and suspends queue 2. When queue 1 stops, queue 2 resumes by itself. A resume-mode input chooses the entry where queue 2 resumes:
- the start of its current subqueue, which is the queue start if no pause has been reached, or
- the entry that was interrupted.

The converter must treat every new start strobe as a restart that discards any conversion in flight. The boundary must not change while either queue is active.

Top module: `dqseq_top`

## Requirements
- R1: A table write with `tbl_we` high stores `tbl_pause` and `tbl_end` for entry `tbl_addr`. Every start strobe for queue 1 carries an index in 0..last1, and every start strobe for queue 2 carries an index in `bound`..63. last1 is `bound`-1, or 63 when `bound` is 64 or more. The first start after a fresh queue 2 trigger is at index `bound`.
- R2: With `bound` of 64 or more, `trig2` is ignored and produces no start. Queue 1 runs entries 0 to 63 and pulses `cmpl1` after entry 63.
- R3: With `bound` equal to 0, `trig1` is ignored and produces no start. Queue 2 runs entries 0 to 63 and pulses `cmpl2` after entry 63.
- R4: After reset every output is low. A trigger accepted while the block is idle makes `start` high in the second cycle after the edge that samples the trigger. `start` never stays high for two consecutive cycles, and only one conversion is outstanding at a time.
- R5: When the done pulse arrives for an entry that has neither flag set and is not the queue's last entry, the next start of the same queue uses the index plus one.
- R6: When the done pulse arrives for an entry with the pause flag set, the block pulses that queue's pause flag one cycle later. The queue then halts. Its next trigger resumes it at the following entry.
- R7: When the done pulse arrives for an entry with the end flag set, or for the queue's last entry, the block pulses that queue's completion flag. The end flag takes priority over the pause flag. The queue's next trigger starts at its first entry.
- R8: A queue 1 trigger accepted while a queue 2 conversion is outstanding abandons that conversion, and a done pulse in that cycle is ignored. The first queue 1 start follows two cycles later.
- R9: With `resume_cont` = 1, a suspended queue 2 resumes at the entry that was being converted when it was suspended.
- R10: With `resume_cont` = 0 and no pause reached since queue 2 last started fresh, a suspended queue 2 resumes at entry `bound`.
- R11: With `resume_cont` = 0 after a pause, a suspended queue 2 resumes at the entry that follows the latest pause. A completed subqueue is not re-run.
- R12: When queue 1 pauses or completes while queue 2 is suspended, queue 2 issues a start in the cycle after the pause or completion pulse, without any trigger.
- R13: A trigger for a queue that is already active has no effect on its order of entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_addr | input | 6 | Entry written |
| tbl_pause | input | 1 | Pause flag of the written entry |
| tbl_end | input | 1 | End flag of the written entry |
| trig1 | input | 1 | Queue 1 trigger pulse |
| trig2 | input | 1 | Queue 2 trigger pulse |
| bound | input | 7 | First entry of queue 2 (64 or more: queue 2 empty) |
| resume_cont | input | 1 | 1: resume at interrupted entry, 0: re-execute subqueue |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| start | output | 1 | One-cycle start-conversion strobe |
| idx | output | 6 | Entry index of the latest start |
| pause1 | output | 1 | Queue 1 reached a pause entry (pulse) |
| cmpl1 | output | 1 | Queue 1 completed (pulse) |
| pause2 | output | 1 | Queue 2 reached a pause entry (pulse) |
| cmpl2 | output | 1 | Queue 2 completed (pulse) |

## Verification
Some properties are checked in every cycle:
- each start index stays inside the range of the queue that owns it;
- a start strobe never lasts two cycles;
- a queue 2 pause leaves the block with no conversion outstanding;
- a queue 1 stop hands over to a suspended queue 2 in the following cycle.

The choice among the three resume points needs the bench's scenarios, as do skipping completed subqueues, ignoring triggers on empty or active queues, and the exact order of entries. For these the bench drives pre-emption at chosen entries under both resume modes and compares against its reference model.

// File: rtl/dqseq_pkg.sv
package dqseq_pkg;
  typedef enum logic {
    OWN_Q1 = 1'b0,
    OWN_Q2 = 1'b1
  } owner_e;

  typedef struct packed {
    logic fin;
    logic halt;
  } cmd_flags_t;
endpackage

// File: rtl/dqseq_cmd_table.sv
module dqseq_cmd_table
  import dqseq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  cmd_flags_t    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output cmd_flags_t    rdata
);
  localparam int DEPTH = 1 << AW;

  cmd_flags_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dqseq_bound.sv
module dqseq_bound #(
  parameter int AW = 6,
  parameter int BW = 7
) (
  input  logic [BW-1:0] bound,
  output logic          q1_none,
  output logic          q2_none,
  output logic [AW-1:0] q1_last,
  output logic [AW-1:0] q2_first
);
  localparam int DEPTH = 1 << AW;

  always_comb begin
    q1_none  = (bound == '0);
    q2_none  = (bound >= BW'(DEPTH));
    q2_first = bound[AW-1:0];
    q1_last  = q2_none ? {AW{1'b1}} : (bound[AW-1:0] - 1'b1);
  end
endmodule

// File: rtl/dqseq_top.sv
module dqseq_top
  import dqseq_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic          tbl_pause,
  input  logic          tbl_end,
  input  logic          trig1,
  input  logic          trig2,
  input  logic [BW-1:0] bound,
  input  logic          resume_cont,
  input  logic          conv_done,
  output logic          start,
  output logic [AW-1:0] idx,
  output logic          pause1,
  output logic          cmpl1,
  output logic          pause2,
  output logic          cmpl2
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          q1_none, q2_none;
  logic [AW-1:0] q1_last, q2_first;
  logic          q1_act, q2_act, busy, fresh2;
  owner_e        own;
  logic [AW-1:0] ptr1, ptr2, sub2, idx_q, nxt_idx, issue_idx;
  logic          start_q, p1_q, c1_q, p2_q, c2_q;
  logic          t1_ok, t2_ok, preempt, done_ev, fin, halt, issue, at_last;
  cmd_flags_t    rd_flags, wr_flags;

  dqseq_bound #(.AW(AW), .BW(BW)) u_bound (
    .bound(bound), .q1_none(q1_none), .q2_none(q2_none),
    .q1_last(q1_last), .q2_first(q2_first)
  );

  assign wr_flags = '{fin: tbl_end, halt: tbl_pause};

  dqseq_cmd_table #(.AW(AW)) u_table (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(wr_flags),
    .re(issue), .raddr(issue_idx), .rdata(rd_flags)
  );

  always_comb begin
    t1_ok     = trig1 && !q1_act && !q1_none;
    t2_ok     = trig2 && !q2_act && !q2_none;
    preempt   = t1_ok && busy && (own == OWN_Q2);
    done_ev   = busy && conv_done && !preempt;
    at_last   = (own == OWN_Q1) ? (idx_q == q1_last) : (idx_q == LAST);
    fin       = done_ev && (rd_flags.fin || at_last);
    halt      = done_ev && !fin && rd_flags.halt;
    issue     = !busy && (q1_act || q2_act);
    issue_idx = q1_act ? ptr1 : ptr2;
    nxt_idx   = idx_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q1_act <= 1'b0; q2_act <= 1'b0; busy <= 1'b0; fresh2 <= 1'b1;
      own <= OWN_Q1; ptr1 <= '0; ptr2 <= '0; sub2 <= '0; idx_q <= '0;
      start_q <= 1'b0; p1_q <= 1'b0; c1_q <= 1'b0; p2_q <= 1'b0; c2_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      p1_q <= 1'b0; c1_q <= 1'b0; p2_q <= 1'b0; c2_q <= 1'b0;
      if (issue) begin
        start_q <= 1'b1;
        idx_q   <= issue_idx;
        busy    <= 1'b1;
        own     <= q1_act ? OWN_Q1 : OWN_Q2;
      end
      if (t1_ok) q1_act <= 1'b1;
      if (t2_ok) begin
        q2_act <= 1'b1;
        if (fresh2) begin
          ptr2 <= q2_first;
          sub2 <= q2_first;
        end
      end
      if (preempt) begin
        busy <= 1'b0;
        ptr2 <= resume_cont ? idx_q : sub2;
      end
      if (done_ev) begin
        busy <= 1'b0;
        if (own == OWN_Q1) begin
          if (fin) begin
            c1_q <= 1'b1; ptr1 <= '0; q1_act <= 1'b0;
          end else if (halt) begin
            p1_q <= 1'b1; ptr1 <= nxt_idx; q1_act <= 1'b0;
          end else begin
            ptr1 <= nxt_idx;
          end
        end else begin
          if (fin) begin
            c2_q <= 1'b1; ptr2 <= q2_first; sub2 <= q2_first;
            fresh2 <= 1'b1; q2_act <= 1'b0;
          end else if (halt) begin
            p2_q <= 1'b1; ptr2 <= nxt_idx; sub2 <= nxt_idx;
            fresh2 <= 1'b0; q2_act <= 1'b0;
          end else begin
            ptr2 <= nxt_idx;
          end
        end
      end
    end
  end

  assign start  = start_q;
  assign idx    = idx_q;
  assign pause1 = p1_q;
  assign cmpl1  = c1_q;
  assign pause2 = p2_q;
  assign cmpl2  = c2_q;

  // R4: a start strobe is never held for two cycles
  p_one_start_r4: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R1: queue 1 starts stay below the boundary
  p_q1_span_r1: assert property (@(posedge clk) disable iff (rst)
    (start_q && own == OWN_Q1) |-> (!q1_none && idx_q <= q1_last));

  // R1, R2: queue 2 starts stay at or above the boundary, never when empty
  p_q2_span_r1: assert property (@(posedge clk) disable iff (rst)
    (start_q && own == OWN_Q2) |-> (!q2_none && idx_q >= q2_first));

  // R6: after a queue 2 pause nothing is outstanding and queue 2 is halted
  p_pause_halts_r6: assert property (@(posedge clk) disable iff (rst)
    p2_q |-> (!busy && !q2_act));

  // R12: a queue 1 stop hands over to a suspended queue 2 at once
  p_handover_r12: assert property (@(posedge clk) disable iff (rst)
    ((p1_q || c1_q) && q2_act) |=> (start_q && own == OWN_Q2));
endmodule

// File: tb/dqseq_top_tb.sv
module dqseq_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0, tbl_pause = 1'b0, tbl_end = 1'b0;
  logic [5:0] tbl_addr = '0;
  logic trig1 = 1'b0, trig2 = 1'b0, resume_cont = 1'b0, conv_done = 1'b0;
  logic [6:0] bound = 7'd64;
  logic start, pause1, cmpl1, pause2, cmpl2;
  logic [5:0] idx;

  int errors = 0, checks = 0, cyc = 0;
  int n_starts = 0, last_idx = -1, cd = 0;
  bit tp[64], te[64];

  // reference model state
  int m_a1, m_a2, m_busy, m_own, m_idx, m_p1, m_p2, m_sub, m_fresh;
  int e_start, e_p1, e_c1, e_p2, e_c2;

  dqseq_top u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_pause(tbl_pause), .tbl_end(tbl_end), .trig1(trig1), .trig2(trig2),
    .bound(bound), .resume_cont(resume_cont), .conv_done(conv_done),
    .start(start), .idx(idx), .pause1(pause1), .cmpl1(cmpl1),
    .pause2(pause2), .cmpl2(cmpl2)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_a1 = 0; m_a2 = 0; m_busy = 0; m_own = 1; m_idx = 0;
      m_p1 = 0; m_p2 = 0; m_sub = 0; m_fresh = 1;
      e_start = 0; e_p1 = 0; e_c1 = 0; e_p2 = 0; e_c2 = 0;
    end else begin
      int b, last1, e;
      bit t1, t2, stop;
      b = int'(bound);
      last1 = (b >= 64) ? 63 : b - 1;
      t1 = trig1 && !m_a1 && (b != 0);
      t2 = trig2 && !m_a2 && (b < 64);
      e_start = 0; e_p1 = 0; e_c1 = 0; e_p2 = 0; e_c2 = 0;
      if (m_busy && t1 && m_own == 2) begin
        m_busy = 0;
        m_p2 = resume_cont ? m_idx : m_sub;
      end else if (m_busy && conv_done) begin
        e = m_idx;
        m_busy = 0;
        stop = te[e] || (m_own == 1 ? e == last1 : e == 63);
        if (m_own == 1) begin
          if (stop) begin e_c1 = 1; m_p1 = 0; m_a1 = 0; end
          else if (tp[e]) begin e_p1 = 1; m_p1 = e + 1; m_a1 = 0; end
          else m_p1 = e + 1;
        end else begin
          if (stop) begin e_c2 = 1; m_p2 = b; m_sub = b; m_fresh = 1; m_a2 = 0; end
          else if (tp[e]) begin e_p2 = 1; m_p2 = e + 1; m_sub = e + 1; m_fresh = 0; m_a2 = 0; end
          else m_p2 = e + 1;
        end
      end else if (!m_busy && (m_a1 || m_a2)) begin
        e_start = 1;
        m_busy = 1;
        m_own = m_a1 ? 1 : 2;
        m_idx = m_a1 ? m_p1 : m_p2;
      end
      if (t1) m_a1 = 1;
      if (t2) begin
        m_a2 = 1;
        if (m_fresh) begin m_p2 = b; m_sub = b; end
      end
    end
  end

  // every-cycle comparison against the model (R5 ordering, flags)
  always @(negedge clk) begin
    if (!rst) begin
      int act, exp;
      act = {start, start ? idx : 6'd0, pause1, cmpl1, pause2, cmpl2};
      exp = {e_start[0], e_start != 0 ? m_idx[5:0] : 6'd0,
             e_p1[0], e_c1[0], e_p2[0], e_c2[0]};
      chk(act == exp, "R5 model", act, exp);
    end
  end

  // converter: done arrives 1..3 cycles after a start; a new start restarts it
  always @(negedge clk) begin
    if (rst) begin
      cd = 0; conv_done = 1'b0;
    end else if (start) begin
      n_starts++;
      last_idx = int'(idx);
      cd = 1 + (n_starts % 3);
      conv_done = 1'b0;
    end else if (cd > 0) begin
      cd--;
      conv_done = (cd == 0);
    end else begin
      conv_done = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic put(input int a, input bit p, input bit e);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 6'(a); tbl_pause = p; tbl_end = e;
    tp[a] = p; te[a] = e;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic pulse(input int q);
    @(negedge clk);
    if (q == 1) trig1 = 1'b1; else trig2 = 1'b1;
    @(negedge clk);
    trig1 = 1'b0; trig2 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_start(input int want, input string tag);
    int k;
    k = 0;
    do begin @(negedge clk); k++; end while (!(start && int'(idx) == want) && k < 3000);
    chk(k < 3000, tag, last_idx, want);
  endtask

  task automatic next_start(input int want, input string tag);
    int k;
    k = 0;
    do begin @(negedge clk); k++; end while (!start && k < 3000);
    chk(start && int'(idx) == want, tag, int'(idx), want);
  endtask

  task automatic wait_flag(input int which, input string tag);
    int k;
    bit f;
    k = 0;
    do begin
      @(negedge clk); k++;
      f = (which == 1) ? pause1 : (which == 2) ? cmpl1 : (which == 3) ? pause2 : cmpl2;
    end while (!f && k < 3000);
    chk(f, tag, 0, 1);
  endtask

  // called at a negedge where a queue 2 start is visible
  task automatic preempt(input int want, input string tag);
    trig1 = 1'b1;
    @(negedge clk);
    trig1 = 1'b0;
    @(negedge clk);
    chk(start && int'(idx) == want, tag, int'(idx), want);
  endtask

  initial begin
    int s0;
    for (int i = 0; i < 64; i++) begin tp[i] = 0; te[i] = 0; end
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk({start, pause1, cmpl1, pause2, cmpl2} == 5'b0, "R4 reset", start, 0);
    for (int i = 0; i < 64; i++) put(i, 1'b0, 1'b0);

    // boundary 64: queue 2 empty
    bound = 7'd64;
    s0 = n_starts;
    pulse(2);
    idle(12);
    chk(n_starts == s0, "R2 trig2 ignored", n_starts - s0, 0);
    trig1 = 1'b1;
    @(negedge clk);
    trig1 = 1'b0;
    @(negedge clk);
    chk(start && idx == 6'd0, "R4 start latency", int'(start), 1);
    idle(20);
    pulse(1);                                   // R13: ignored while active
    wait_flag(2, "R2 cmpl1");
    chk(n_starts - s0 == 64, "R13 no restart", n_starts - s0, 64);
    chk(last_idx == 63, "R2 last entry", last_idx, 63);

    // boundary 0: queue 1 empty
    bound = 7'd0;
    s0 = n_starts;
    pulse(1);
    idle(12);
    chk(n_starts == s0, "R3 trig1 ignored", n_starts - s0, 0);
    pulse(2);
    next_start(0, "R3 q2 from 0");
    wait_flag(4, "R3 cmpl2");
    chk(n_starts - s0 == 64 && last_idx == 63, "R3 full span", n_starts - s0, 64);

    // split table with pause and end marks
    put(3, 1'b1, 1'b0);
    put(5, 1'b0, 1'b1);
    put(12, 1'b1, 1'b0);
    put(20, 1'b1, 1'b0);
    bound = 7'd8;
    s0 = n_starts;
    pulse(1);
    wait_flag(1, "R6 pause1");
    chk(n_starts - s0 == 4 && last_idx == 3, "R5 order 0..3", last_idx, 3);
    pulse(1);
    next_start(4, "R6 continue after pause");
    wait_flag(2, "R7 cmpl1 at end mark");
    chk(last_idx == 5, "R7 end mark", last_idx, 5);

    // re-execute mode, no pause yet
    resume_cont = 1'b0;
    pulse(2);
    next_start(8, "R1 q2 first entry");
    wait_start(10, "R8 reach 10");
    preempt(0, "R8 q1 pre-empts");
    wait_flag(1, "R8 q1 pause");
    @(negedge clk);
    chk(start && idx == 6'd8, "R10 R12 resume at start", int'(idx), 8);
    wait_flag(3, "R6 pause2");
    chk(last_idx == 12, "R6 pause2 entry", last_idx, 12);

    // re-execute mode after a pause
    pulse(2);
    next_start(13, "R6 q2 next subqueue");
    wait_start(15, "R11 reach 15");
    preempt(4, "R8 q1 pre-empts again");
    wait_flag(2, "R11 q1 done");
    @(negedge clk);
    chk(start && idx == 6'd13, "R11 R12 resume at subqueue", int'(idx), 13);
    wait_flag(3, "R11 pause at 20");
    chk(last_idx == 20, "R11 subqueue end", last_idx, 20);

    // continue mode
    resume_cont = 1'b1;
    pulse(2);
    next_start(21, "R11 no repeat");
    wait_start(30, "R9 reach 30");
    preempt(0, "R8 q1 pre-empts third");
    wait_flag(1, "R9 q1 pause");
    @(negedge clk);
    chk(start && idx == 6'd30, "R9 resume at interrupted", int'(idx), 30);
    wait_start(40, "R13 reach 40");
    pulse(2);
    wait_flag(4, "R7 cmpl2");
    chk(last_idx == 63, "R7 q2 last", last_idx, 63);
    pulse(2);
    next_start(8, "R7 restart at first");
    idle(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule